// File: doc/BRIEF.md
# Debug Serial Port

A small serial console port for a debug channel, reached through a 32-bit register window. Software writes one character at a time to a transmit register and the block sends it on `txd` as a ten-bit frame: one low start bit, eight data bits least significant first, and one high stop bit. Characters arriving on `rxd` are shifted in and placed in a single receive holding register. A level interrupt is raised whenever a status flag that software has unmasked is set.

The bit period is the system clock divided by the oversampling factor times the baud divider register. With the default oversampling of 16 and a divider of N, one bit lasts 16·N clock cycles. A divider of zero stops the baud clock. The receiver checks the start bit at its middle and samples every later bit at its middle. Flags are cleared as a side effect of data register accesses and of control writes. The interrupt mask is never written directly: separate set and clear registers each take write-one strobes.

Register byte offsets: control 0x00 (write only), mode 0x04, mask-set 0x08, mask-clear 0x0C, mask 0x10 (read), status 0x14 (read), receive data 0x18 (read), transmit data 0x1C (write), divider 0x20. Status bits: 0 receive-ready, 1 transmit-ready, 5 overrun, 6 framing error, 7 parity error (always 0 here), 9 transmitter-empty. Control bits: 2 receiver reset, 3 transmitter reset, 4 receive on, 5 receive off, 6 transmit on, 7 transmit off, 8 clear error flags.

Top module: `dbg_serial`

## Requirements
- R1: After reset, status reads 0x202, and mask, mode, divider and receive data all read 0. `irq` is low and `txd` is high.
- R2: Writing control bit 6 sets status bits 1 and 9. Writing control bit 7 clears them. When both bits are written together, bit 7 wins.
- R3: A write to the transmit data register (0x1C) while no frame is in progress clears status bits 1 and 9 at once. It sends start 0, the eight data bits LSB first, and stop 1 on `txd`, each bit lasting 16·divider cycles. Status bits 1 and 9 are set again when the frame ends. `txd` is high whenever no frame is in progress.
- R4: While receive is on (control bit 4 turns it on, bit 5 turns it off), a frame that is still low at the middle of its start bit is sampled mid-bit into the receive data register (0x18), and status bit 0 is set. While receive is off, a frame on `rxd` changes neither status bit 0 nor the receive data register.
- R5: Reading the receive data register clears status bit 0.
- R6: A character that completes while status bit 0 is still set overwrites the receive data register and sets status bit 5.
- R7: A character whose stop bit is sampled low is still stored, and it sets status bit 6.
- R8: Writing control bit 8 clears status bits 5, 6 and 7.
- R9: A write to 0x08 ORs the written value into the mask. A write to 0x0C clears the written bits from the mask. The mask reads at 0x10.
- R10: `irq` is high exactly when the mask ANDed with the status is nonzero.
- R11: With the divider at 0 a started frame makes no progress: `txd` stays high after the start bit has been driven is not required, but status bit 9 stays clear until a nonzero divider lets the frame finish.
- R12: The mode register reads back the full written word. The divider register reads back the low 16 bits of the written word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe; a read of 0x18 carries a side effect |
| bus_addr | input | 8 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the same cycle as the address |
| irq | output | 1 | Level interrupt request |
| txd | output | 1 | Serial transmit line, idle high |
| rxd | input | 1 | Serial receive line, idle high |

## Verification
The bench builds the block with its default parameters: an 8-bit address, a 16-bit divider, 16-times oversampling and a two-stage input synchronizer. It programs a divider of 2, which gives 32-cycle bits and 320-cycle frames, so every transmit, receive, overrun and framing scenario runs in a few hundred cycles. Because the divider is 16 bits wide, a 17-bit write shows the truncation at the port. Setting the divider to zero in the middle of a frame exercises the stopped baud clock, and restoring it lets the bench watch the frame finish.

// File: rtl/dbg_serial_pkg.sv
package dbg_serial_pkg;
   // byte offsets of the register window
   localparam logic [7:0] OFF_CTRL  = 8'h00;
   localparam logic [7:0] OFF_MODE  = 8'h04;
   localparam logic [7:0] OFF_MSET  = 8'h08;
   localparam logic [7:0] OFF_MCLR  = 8'h0C;
   localparam logic [7:0] OFF_MASK  = 8'h10;
   localparam logic [7:0] OFF_STAT  = 8'h14;
   localparam logic [7:0] OFF_RDATA = 8'h18;
   localparam logic [7:0] OFF_TDATA = 8'h1C;
   localparam logic [7:0] OFF_DIV   = 8'h20;

   // status bit positions
   localparam int ST_RXRDY  = 0;
   localparam int ST_TXRDY  = 1;
   localparam int ST_OVR    = 5;
   localparam int ST_FRM    = 6;
   localparam int ST_PAR    = 7;
   localparam int ST_TXEMPT = 9;

   // control bit positions
   localparam int CT_RXRST = 2;
   localparam int CT_TXRST = 3;
   localparam int CT_RXON  = 4;
   localparam int CT_RXOFF = 5;
   localparam int CT_TXON  = 6;
   localparam int CT_TXOFF = 7;
   localparam int CT_CLRER = 8;

   localparam int CHAR_BITS  = 8;
   localparam int FRAME_BITS = CHAR_BITS + 2;

   typedef enum logic [1:0] {RX_IDLE, RX_START, RX_DATA, RX_STOP} rx_state_e;
endpackage

// File: rtl/dbg_serial_baud.sv
module dbg_serial_baud #(
   parameter int DIV_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [DIV_W-1:0] div_i,
   output logic             tick_o
);
   logic [DIV_W-1:0] cnt_q;
   logic             hit;

   assign hit    = (div_i != '0) && (cnt_q >= div_i - 1'b1);
   assign tick_o = hit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                       cnt_q <= '0;
      else if (hit || div_i == '0)      cnt_q <= '0;
      else                              cnt_q <= cnt_q + 1'b1;
   end

   AST_DIV0_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
      (div_i == '0) |=> (cnt_q == '0)) else $error("divider 0 left counter running"); // R11
endmodule

// File: rtl/dbg_serial_tx.sv
module dbg_serial_tx
   import dbg_serial_pkg::*;
#(
   parameter int OVS = 16
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 tick_i,
   input  logic                 start_i,
   input  logic                 abort_i,
   input  logic [CHAR_BITS-1:0] data_i,
   output logic                 txd_o,
   output logic                 busy_o,
   output logic                 done_o
);
   localparam int CW = $clog2(OVS);
   localparam logic [CW-1:0] LAST_T = CW'(OVS - 1);
   localparam logic [3:0]    LAST_B = 4'(FRAME_BITS - 1);

   logic [FRAME_BITS-1:0] frame_q;
   logic [3:0]            bit_q;
   logic [CW-1:0]         tcnt_q;
   logic                  busy_q, done_q, txd_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         frame_q <= '1; bit_q <= '0; tcnt_q <= '0;
         busy_q  <= 1'b0; done_q <= 1'b0; txd_q <= 1'b1;
      end else begin
         done_q <= 1'b0;
         if (abort_i) begin
            busy_q <= 1'b0;
            txd_q  <= 1'b1;
         end else if (start_i && !busy_q) begin
            frame_q <= {1'b1, data_i, 1'b0};
            busy_q  <= 1'b1;
            bit_q   <= '0;
            tcnt_q  <= '0;
            txd_q   <= 1'b0;
         end else if (busy_q && tick_i) begin
            if (tcnt_q == LAST_T) begin
               tcnt_q <= '0;
               if (bit_q == LAST_B) begin
                  busy_q <= 1'b0;
                  done_q <= 1'b1;
                  txd_q  <= 1'b1;
               end else begin
                  bit_q <= bit_q + 4'd1;
                  txd_q <= frame_q[bit_q + 4'd1];
               end
            end else begin
               tcnt_q <= tcnt_q + 1'b1;
            end
         end
      end
   end

   assign txd_o  = txd_q;
   assign busy_o = busy_q;
   assign done_o = done_q;

   AST_TX_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_q |-> txd_q) else $error("line low while idle"); // R3
endmodule

// File: rtl/dbg_serial_rx.sv
module dbg_serial_rx
   import dbg_serial_pkg::*;
#(
   parameter int OVS = 16
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 tick_i,
   input  logic                 en_i,
   input  logic                 abort_i,
   input  logic                 rxd_i,
   output logic                 done_o,
   output logic                 frm_err_o,
   output logic [CHAR_BITS-1:0] data_o
);
   localparam int CW = $clog2(OVS);
   localparam logic [CW-1:0] HALF_T = CW'(OVS / 2 - 1);
   localparam logic [CW-1:0] LAST_T = CW'(OVS - 1);

   rx_state_e            st_q;
   logic [CW-1:0]        cnt_q;
   logic [2:0]           bit_q;
   logic [CHAR_BITS-1:0] sh_q;
   logic                 prev_q, done_q, frm_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q <= RX_IDLE; cnt_q <= '0; bit_q <= '0; sh_q <= '0;
         prev_q <= 1'b1; done_q <= 1'b0; frm_q <= 1'b0;
      end else begin
         prev_q <= rxd_i;
         done_q <= 1'b0;
         frm_q  <= 1'b0;
         if (abort_i || !en_i) begin
            st_q <= RX_IDLE;
         end else begin
            case (st_q)
               RX_IDLE: if (prev_q && !rxd_i) begin
                  st_q  <= RX_START;
                  cnt_q <= '0;
               end
               RX_START: if (tick_i) begin
                  if (cnt_q == HALF_T) begin
                     cnt_q <= '0;
                     bit_q <= '0;
                     st_q  <= rxd_i ? RX_IDLE : RX_DATA;
                  end else cnt_q <= cnt_q + 1'b1;
               end
               RX_DATA: if (tick_i) begin
                  if (cnt_q == LAST_T) begin
                     cnt_q <= '0;
                     sh_q  <= {rxd_i, sh_q[CHAR_BITS-1:1]};
                     if (bit_q == 3'(CHAR_BITS - 1)) st_q <= RX_STOP;
                     else                             bit_q <= bit_q + 3'd1;
                  end else cnt_q <= cnt_q + 1'b1;
               end
               RX_STOP: if (tick_i) begin
                  if (cnt_q == LAST_T) begin
                     done_q <= 1'b1;
                     frm_q  <= !rxd_i;
                     st_q   <= RX_IDLE;
                  end else cnt_q <= cnt_q + 1'b1;
               end
               default: st_q <= RX_IDLE;
            endcase
         end
      end
   end

   assign done_o    = done_q;
   assign frm_err_o = frm_q;
   assign data_o    = sh_q;

   AST_RX_ERR_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      frm_q |-> done_q) else $error("framing pulse without a character"); // R7
endmodule

// File: rtl/dbg_serial.sv
module dbg_serial
   import dbg_serial_pkg::*;
#(
   parameter int ADDR_W      = 8,
   parameter int DIV_W       = 16,
   parameter int OVS         = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   output logic              irq,
   output logic              txd,
   input  logic              rxd
);
   localparam int PAD_W = 32 - DIV_W;

   generate
      if (ADDR_W < 6 || ADDR_W > 8) begin : g_bad_addr
         $error("ADDR_W must lie between 6 and 8");
      end
      if (OVS < 4 || (OVS % 2) != 0) begin : g_bad_ovs
         $error("OVS must be even and at least 4");
      end
      if (DIV_W < 1 || DIV_W > 31) begin : g_bad_div
         $error("DIV_W must lie between 1 and 31");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic [7:0] a8;
   assign a8 = 8'(bus_addr);

   logic wr_ctrl, wr_mode, wr_mset, wr_mclr, wr_tdata, wr_div, rd_rdata;
   assign wr_ctrl  = bus_wr && a8 == OFF_CTRL;
   assign wr_mode  = bus_wr && a8 == OFF_MODE;
   assign wr_mset  = bus_wr && a8 == OFF_MSET;
   assign wr_mclr  = bus_wr && a8 == OFF_MCLR;
   assign wr_tdata = bus_wr && a8 == OFF_TDATA;
   assign wr_div   = bus_wr && a8 == OFF_DIV;
   assign rd_rdata = bus_rd && a8 == OFF_RDATA;

   logic [31:0]          mode_q, mask_q;
   logic [DIV_W-1:0]     div_q;
   logic [CHAR_BITS-1:0] rdata_q;
   logic                 rxrdy_q, txrdy_q, txempt_q, ovr_q, frm_q, rxen_q;
   logic [31:0]          stat;

   // input synchronizer, idle high out of reset
   logic [SYNC_STAGES-1:0] sync_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sync_q <= '1;
      else        sync_q <= {sync_q[SYNC_STAGES-2:0], rxd};
   end

   logic tick, tx_busy, tx_done, tx_start, rx_done, rx_frm;
   logic [CHAR_BITS-1:0] rx_byte;
   assign tx_start = wr_tdata && !tx_busy;

   dbg_serial_baud #(.DIV_W(DIV_W)) u_baud (
      .clk(clk), .rst_n(rst_n), .div_i(div_q), .tick_o(tick));

   dbg_serial_tx #(.OVS(OVS)) u_tx (
      .clk(clk), .rst_n(rst_n), .tick_i(tick), .start_i(tx_start),
      .abort_i(wr_ctrl && bus_wdata[CT_TXRST]), .data_i(bus_wdata[CHAR_BITS-1:0]),
      .txd_o(txd), .busy_o(tx_busy), .done_o(tx_done));

   dbg_serial_rx #(.OVS(OVS)) u_rx (
      .clk(clk), .rst_n(rst_n), .tick_i(tick), .en_i(rxen_q),
      .abort_i(wr_ctrl && bus_wdata[CT_RXRST]), .rxd_i(sync_q[SYNC_STAGES-1]),
      .done_o(rx_done), .frm_err_o(rx_frm), .data_o(rx_byte));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q <= '0; mask_q <= '0; div_q <= '0; rdata_q <= '0;
         rxrdy_q <= 1'b0; txrdy_q <= 1'b1; txempt_q <= 1'b1;
         ovr_q <= 1'b0; frm_q <= 1'b0; rxen_q <= 1'b0;
      end else begin
         if (wr_mode) mode_q <= bus_wdata;
         if (wr_div)  div_q  <= bus_wdata[DIV_W-1:0];
         if (wr_mset) mask_q <= mask_q | bus_wdata;
         if (wr_mclr) mask_q <= mask_q & ~bus_wdata;
         if (tx_done) begin
            txrdy_q  <= 1'b1;
            txempt_q <= 1'b1;
         end
         if (rx_done) begin
            rdata_q <= rx_byte;
            rxrdy_q <= 1'b1;
            if (rxrdy_q) ovr_q <= 1'b1;
            if (rx_frm)  frm_q <= 1'b1;
         end else if (rd_rdata) begin
            rxrdy_q <= 1'b0;
         end
         if (tx_start) begin
            txrdy_q  <= 1'b0;
            txempt_q <= 1'b0;
         end
         if (wr_ctrl) begin
            if (bus_wdata[CT_RXON])  rxen_q <= 1'b1;
            if (bus_wdata[CT_RXOFF]) rxen_q <= 1'b0;
            if (bus_wdata[CT_RXRST]) rxrdy_q <= 1'b0;
            if (bus_wdata[CT_TXON]) begin
               txrdy_q <= 1'b1; txempt_q <= 1'b1;
            end
            if (bus_wdata[CT_TXOFF] || bus_wdata[CT_TXRST]) begin
               txrdy_q <= 1'b0; txempt_q <= 1'b0;
            end
            if (bus_wdata[CT_CLRER]) begin
               ovr_q <= 1'b0; frm_q <= 1'b0;
            end
         end
      end
   end

   always_comb begin
      stat            = '0;
      stat[ST_RXRDY]  = rxrdy_q;
      stat[ST_TXRDY]  = txrdy_q;
      stat[ST_OVR]    = ovr_q;
      stat[ST_FRM]    = frm_q;
      stat[ST_PAR]    = 1'b0;
      stat[ST_TXEMPT] = txempt_q;
   end

   always_comb begin
      case (a8)
         OFF_MODE:  bus_rdata = mode_q;
         OFF_MASK:  bus_rdata = mask_q;
         OFF_STAT:  bus_rdata = stat;
         OFF_RDATA: bus_rdata = {{(32-CHAR_BITS){1'b0}}, rdata_q};
         OFF_DIV:   bus_rdata = {{PAD_W{1'b0}}, div_q};
         default:   bus_rdata = '0;
      endcase
   end

   assign irq = |(mask_q & stat);

   AST_SEND_CLEARS_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
      tx_start |=> (!txrdy_q && !txempt_q)) else $error("send left flags set"); // R3
   AST_READ_CLEARS_RXRDY: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_rdata && !rx_done) |=> !rxrdy_q) else $error("read left rxrdy set"); // R5
   AST_MCLR_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      wr_mclr |=> ((mask_q & $past(bus_wdata)) == '0)) else $error("mask bits survived"); // R9
   AST_CLRER_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_ctrl && bus_wdata[CT_CLRER]) |=> (!ovr_q && !frm_q)) else $error("error flags survived"); // R8
   AST_OVR_ON_FULL: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_done && rxrdy_q && !(wr_ctrl && bus_wdata[CT_CLRER])) |=> ovr_q) else $error("overrun missed"); // R6
endmodule

// File: tb/dbg_serial_bench.sv
module dbg_serial_bench;
   localparam int CLK_PERIOD = 10;
   localparam int BIT_CYC    = 32;   // 16 oversampling x divider 2

   logic        clk = 1'b0, rst_n = 1'b0;
   logic        bus_wr = 1'b0, bus_rd = 1'b0, rxd = 1'b1;
   logic [7:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0, bus_rdata;
   logic        irq, txd;
   int          n_chk = 0, n_fail = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   dbg_serial u_dbg_serial (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .irq(irq), .txd(txd), .rxd(rxd));

   task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk); bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] d);
      @(negedge clk); bus_rd = 1'b1; bus_addr = a;
      #1 d = bus_rdata;
      @(negedge clk); bus_rd = 1'b0;
   endtask

   task automatic rd_chk(input logic [7:0] a, input logic [31:0] msk, input logic [31:0] exp, input string req);
      logic [31:0] v;
      rd(a, v);
      check((v & msk) == exp, req, v & msk, exp);
   endtask

   task automatic send_rx(input logic [7:0] b, input bit stop);
      logic [9:0] fr;
      fr = {stop, b, 1'b0};
      for (int i = 0; i < 10; i++) begin
         @(negedge clk); rxd = fr[i];
         repeat (BIT_CYC - 1) @(negedge clk);
      end
      @(negedge clk); rxd = 1'b1;
      repeat (10) @(negedge clk);
   endtask

   task automatic t_reset;
      rd_chk(8'h14, 32'hFFFF_FFFF, 32'h202, "R1 status");
      rd_chk(8'h10, 32'hFFFF_FFFF, 32'h0, "R1 mask");
      rd_chk(8'h04, 32'hFFFF_FFFF, 32'h0, "R1 mode");
      rd_chk(8'h20, 32'hFFFF_FFFF, 32'h0, "R1 divider");
      rd_chk(8'h18, 32'hFFFF_FFFF, 32'h0, "R1 rdata");
      check(irq == 1'b0, "R1 irq", 32'(irq), 0);
      check(txd == 1'b1, "R1 txd", 32'(txd), 1);
   endtask

   task automatic t_regs;
      wr(8'h04, 32'hA5C3_0F11);
      rd_chk(8'h04, 32'hFFFF_FFFF, 32'hA5C3_0F11, "R12 mode");
      wr(8'h20, 32'h0001_2345);
      rd_chk(8'h20, 32'hFFFF_FFFF, 32'h2345, "R12 divider trunc");
      wr(8'h20, 32'd2);
   endtask

   task automatic t_ctrl;
      wr(8'h00, 32'h80);
      rd_chk(8'h14, 32'hFFFF_FFFF, 32'h000, "R2 tx off");
      wr(8'h00, 32'h40);
      rd_chk(8'h14, 32'hFFFF_FFFF, 32'h202, "R2 tx on");
      wr(8'h00, 32'hC0);
      rd_chk(8'h14, 32'hFFFF_FFFF, 32'h000, "R2 both, off wins");
      wr(8'h00, 32'h40);
   endtask

   task automatic t_tx(input logic [7:0] b);
      logic [7:0] got;
      int  w;
      bit  seen;
      wr(8'h1C, {24'h0, b});
      rd_chk(8'h14, 32'h202, 32'h000, "R3 flags cleared on send");
      seen = 1'b0;
      for (w = 0; w < 200 && !seen; w++) begin
         @(negedge clk);
         if (txd == 1'b0) seen = 1'b1;
      end
      check(seen, "R3 start edge", 32'(seen), 1);
      repeat (BIT_CYC/2) @(negedge clk);
      check(txd == 1'b0, "R3 start bit", 32'(txd), 0);
      for (int i = 0; i < 8; i++) begin
         repeat (BIT_CYC) @(negedge clk);
         got[i] = txd;
      end
      check(got == b, "R3 data bits", 32'(got), 32'(b));
      repeat (BIT_CYC) @(negedge clk);
      check(txd == 1'b1, "R3 stop bit", 32'(txd), 1);
      repeat (BIT_CYC) @(negedge clk);
      rd_chk(8'h14, 32'h202, 32'h202, "R3 flags set after frame");
   endtask

   task automatic t_rx;
      wr(8'h00, 32'h10);
      send_rx(8'h3C, 1'b1);
      rd_chk(8'h14, 32'h1, 32'h1, "R4 rxrdy set");
      rd_chk(8'h18, 32'hFF, 32'h3C, "R4 data");
      rd_chk(8'h14, 32'h1, 32'h0, "R5 rxrdy cleared by read");
      send_rx(8'h11, 1'b1);
      send_rx(8'hE2, 1'b1);
      rd_chk(8'h14, 32'h21, 32'h21, "R6 overrun");
      rd_chk(8'h18, 32'hFF, 32'hE2, "R6 overwrite");
      wr(8'h00, 32'h100);
      rd_chk(8'h14, 32'hE0, 32'h0, "R8 errors cleared");
      send_rx(8'h55, 1'b0);
      rd_chk(8'h14, 32'h61, 32'h41, "R7 framing");
      rd_chk(8'h18, 32'hFF, 32'h55, "R7 stored");
      wr(8'h00, 32'h100);
      rd_chk(8'h14, 32'hE0, 32'h0, "R8 framing cleared");
      wr(8'h00, 32'h20);
      send_rx(8'h77, 1'b1);
      rd_chk(8'h14, 32'h1, 32'h0, "R4 off: no rxrdy");
      rd_chk(8'h18, 32'hFF, 32'h55, "R4 off: data kept");
      wr(8'h00, 32'h10);
   endtask

   task automatic t_irq;
      wr(8'h08, 32'h2);
      check(irq == 1'b1, "R10 irq on txrdy", 32'(irq), 1);
      wr(8'h08, 32'h1);
      rd_chk(8'h10, 32'hFFFF_FFFF, 32'h3, "R9 mask or");
      wr(8'h0C, 32'h2);
      rd_chk(8'h10, 32'hFFFF_FFFF, 32'h1, "R9 mask clear");
      check(irq == 1'b0, "R10 irq low", 32'(irq), 0);
      send_rx(8'h9A, 1'b1);
      check(irq == 1'b1, "R10 irq on rxrdy", 32'(irq), 1);
      rd_chk(8'h18, 32'hFF, 32'h9A, "R4 data irq case");
      check(irq == 1'b0, "R10 irq after read", 32'(irq), 0);
      wr(8'h0C, 32'h1);
   endtask

   task automatic t_div0;
      wr(8'h20, 32'd0);
      wr(8'h1C, 32'hF0);
      repeat (400) @(negedge clk);
      rd_chk(8'h14, 32'h202, 32'h000, "R11 stalled at divider 0");
      wr(8'h20, 32'd2);
      repeat (400) @(negedge clk);
      rd_chk(8'h14, 32'h202, 32'h202, "R11 finishes after restore");
      check(txd == 1'b1, "R11 line idle", 32'(txd), 1);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_regs();
      t_ctrl();
      t_tx(8'h5A);
      t_tx(8'h81);
      t_rx();
      t_irq();
      t_div0();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=0x0 expected=0x1");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule